// File: doc/BRIEF.md
# Multi-Channel Match Timer

This block is a register-mapped timer peripheral with several independent up-counters. Each counter has a set of match comparators. Each comparator owns a sticky status bit and an interrupt enable bit. A per-timer mode bit selects periodic operation or free-running operation. In periodic mode the counter returns to zero after it reaches match 0. In free-running mode it wraps over its full width. One enable register starts and stops the counters bit by bit. A per-timer capture register snapshots the running count when software asks, so that a later read is coherent. Each timer drives its own interrupt line, the OR of its enabled pending matches.

Software talks to the block over a simple synchronous register bus: word address, write data, write strobe, read strobe and registered read data. A one-shot event due `delta` ticks after the enable is set up in three steps: load a match register with `delta - 1`, enable its interrupt, then set the timer's enable bit. The counter advances once per `clk_i` cycle. Any tick prescaling or clock selection happens outside the block.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads 0, except the match registers, which read 0xFFFFFFFF. All irq_o bits are low.
- R2: Word address 0x00 is the enable register, and bit t runs timer t. A write that takes bit t from 0 to 1 restarts that counter at 0. Writing 1 to a bit that is already set does not restart the counter. A timer whose bit is 0 holds its count.
- R3: In free-running mode (mode register bit 0 = 0), a running counter rises by one every clock cycle and wraps across its full width.
- R4: In periodic mode (mode register bit 0 = 1), a running counter that equals match 0 returns to 0 on the next cycle, so the period is match0 + 1 cycles.
- R5: Status bit m sets on the clock edge that ends a cycle in which the running count equals match m. A match loaded with delta - 1 therefore sets its status exactly delta edges after the enable write.
- R6: Status reads at offset 3 and is write-one-to-clear: data bit m clears match m, and zero bits leave their status untouched. A match in the same cycle as a clear keeps the bit set.
- R7: irq_o[t] is high exactly when some status bit of timer t is set and its interrupt enable bit (offset 4, bit m) is set.
- R8: Writing 1 in bit 0 at offset 6 latches the count present during that write cycle into the capture register. Reads at offset 6 return that value until the next capture write.
- R9: Timer t occupies word addresses 0x10 + 8t: offsets 0 to 2 are match 0 to 2, 3 is status/clear, 4 is interrupt enable, 5 is mode and 6 is capture. rdata_o shows the addressed register on the edge after a cycle with rd_i high, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the count tick |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (8) | Word address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | N_TMR (3) | Per-timer combined interrupt |

## Verification
The results become visible at fixed delays after their stimulus:
- A read returns data on the edge after its strobe.
- A counter reads 0 during the cycle after its enable edge and k - 1 when a capture is written k edges after that enable.
- A status bit, and its interrupt line, becomes visible one edge after the cycle in which the count equals the match value.

The bench numbers every clock edge and moves stimulus to chosen edges only. It derives each expected value from the edge indices of the enable, capture and clear writes. It samples on the falling edge that follows the edge on which the result is due. Read results go through a queue and are compared in the cycle after each strobe.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned OFF_W = 3;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd3;
  localparam logic [OFF_W-1:0] OFF_IEN  = 3'd4;
  localparam logic [OFF_W-1:0] OFF_MODE = 3'd5;
  localparam logic [OFF_W-1:0] OFF_CAPT = 3'd6;
endpackage

// File: rtl/match_timer_cmp.sv
module match_timer_cmp #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] match_o,
  output logic             hit_o,
  output logic             stat_o
);
  logic [CNT_W-1:0] match_q;
  logic             stat_q;

  assign hit_o   = run_i && (cnt_i == match_q);
  assign match_o = match_q;
  assign stat_o  = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '1;
      stat_q  <= 1'b0;
    end else begin
      if (we_i) match_q <= wdata_i;
      // a hit overrides a clear in the same cycle
      stat_q <= (stat_q && !clr_i) || hit_o;
    end
  end
endmodule

// File: rtl/match_timer_chan.sv
module match_timer_chan import match_timer_pkg::*; #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned N_MATCH = 3   // at most 3: offsets 0..2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               start_i,
  input  logic               wr_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [N_MATCH-1:0] stat_o,
  output logic               periodic_o,
  output logic               irq_o
);
  logic [CNT_W-1:0]              cnt_q, cap_q;
  logic [N_MATCH-1:0]            ien_q, hit_w, stat_w;
  logic                          periodic_q;
  logic [N_MATCH-1:0][CNT_W-1:0] match_w;

  for (genvar m = 0; m < N_MATCH; m++) begin : g_cmp
    match_timer_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_i && (off_i == OFF_W'(m))),
      .wdata_i(wdata_i[CNT_W-1:0]),
      .clr_i  (wr_i && (off_i == OFF_STAT) && wdata_i[m]),
      .run_i  (run_i),
      .cnt_i  (cnt_q),
      .match_o(match_w[m]),
      .hit_o  (hit_w[m]),
      .stat_o (stat_w[m])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      cap_q      <= '0;
      ien_q      <= '0;
      periodic_q <= 1'b0;
    end else begin
      if (start_i)                          cnt_q <= '0;
      else if (run_i && periodic_q && hit_w[0]) cnt_q <= '0;
      else if (run_i)                       cnt_q <= cnt_q + 1'b1;
      if (wr_i && off_i == OFF_IEN)  ien_q      <= wdata_i[N_MATCH-1:0];
      if (wr_i && off_i == OFF_MODE) periodic_q <= wdata_i[0];
      if (wr_i && off_i == OFF_CAPT && wdata_i[0]) cap_q <= cnt_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_STAT: rdata_o = BUS_W'(stat_w);
      OFF_IEN:  rdata_o = BUS_W'(ien_q);
      OFF_MODE: rdata_o = BUS_W'(periodic_q);
      OFF_CAPT: rdata_o = BUS_W'(cap_q);
      default: begin
        for (int m = 0; m < N_MATCH; m++)
          if (off_i == OFF_W'(m)) rdata_o = BUS_W'(match_w[m]);
      end
    endcase
  end

  assign cnt_o      = cnt_q;
  assign stat_o     = stat_w;
  assign periodic_o = periodic_q;
  assign irq_o      = |(stat_w & ien_q);
endmodule

// File: rtl/match_timer.sv
module match_timer import match_timer_pkg::*; #(
  parameter int unsigned N_TMR   = 3,
  parameter int unsigned N_MATCH = 3,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [N_TMR-1:0]  irq_o
);
  localparam int unsigned       SEL_W   = ADDR_W - OFF_W;
  localparam int unsigned       CH_BASE = 2;  // timer t at 0x10 + 8t
  localparam logic [ADDR_W-1:0] EN_ADDR = '0;

  logic [N_TMR-1:0]              en_q, start_w, ch_sel, periodic_w;
  logic [N_TMR-1:0][CNT_W-1:0]   cnt_w;
  logic [N_TMR-1:0][N_MATCH-1:0] stat_w;
  logic [N_TMR-1:0][BUS_W-1:0]   ch_rdata;
  logic [BUS_W-1:0]              rd_mux, rdata_q;
  logic                          en_wr;

  assign en_wr   = wr_i && (addr_i == EN_ADDR);
  assign start_w = {N_TMR{en_wr}} & wdata_i[N_TMR-1:0] & ~en_q;

  for (genvar t = 0; t < N_TMR; t++) begin : g_ch
    assign ch_sel[t] = (addr_i[ADDR_W-1:OFF_W] == SEL_W'(CH_BASE + t));
    match_timer_chan #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (en_q[t]),
      .start_i   (start_w[t]),
      .wr_i      (wr_i && ch_sel[t]),
      .off_i     (addr_i[OFF_W-1:0]),
      .wdata_i   (wdata_i),
      .rdata_o   (ch_rdata[t]),
      .cnt_o     (cnt_w[t]),
      .stat_o    (stat_w[t]),
      .periodic_o(periodic_w[t]),
      .irq_o     (irq_o[t])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == EN_ADDR) rd_mux = BUS_W'(en_q);
    for (int t = 0; t < N_TMR; t++)
      if (ch_sel[t]) rd_mux = ch_rdata[t];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (en_wr) en_q    <= wdata_i[N_TMR-1:0];
      if (rd_i)  rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int unsigned N_TMR   = 3,
  parameter int unsigned N_MATCH = 3,
  parameter int unsigned CNT_W   = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_i,
  input logic [N_TMR-1:0]              en_q,
  input logic [N_TMR-1:0][CNT_W-1:0]   cnt_w,
  input logic [N_TMR-1:0][N_MATCH-1:0] stat_w,
  input logic [N_TMR-1:0]              periodic_w
);
  for (genvar t = 0; t < N_TMR; t++) begin : g_t
    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_q[t] && !$past(en_q[t])) |-> $stable(cnt_w[t]));
    p_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_q[t]) |-> (cnt_w[t] == '0));
    p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[t] && $past(en_q[t]) && !$past(periodic_w[t]))
        |-> (cnt_w[t] == CNT_W'($past(cnt_w[t]) + 1'b1)));
    p_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[t] && $past(en_q[t]) && $past(periodic_w[t]))
        |-> (cnt_w[t] == '0 || cnt_w[t] == CNT_W'($past(cnt_w[t]) + 1'b1)));
    for (genvar m = 0; m < N_MATCH; m++) begin : g_m
      p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(stat_w[t][m]) && !$past(wr_i)) |-> stat_w[t][m]);
    end
  end
endmodule

bind match_timer match_timer_chk #(
  .N_TMR(N_TMR), .N_MATCH(N_MATCH), .CNT_W(CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .en_q      (en_q),
  .cnt_w     (cnt_w),
  .stat_w    (stat_w),
  .periodic_w(periodic_w)
);

// File: tb/match_timer_tb.sv
module match_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic [2:0]  irq_o;

  match_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  int  n_chk = 0, n_err = 0;
  bit  done = 1'b0;
  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  logic rd_d = 1'b0;
  always @(posedge clk) rd_d <= rd_i;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: read data is due the edge after the strobe
  always @(negedge clk) begin
    item_t it;
    if (rd_d) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R9: actual unexpected read %h expected none", rdata_o);
      end else begin
        it = sb_q.pop_front();
        check(it.tag, rdata_o, it.exp);
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, output int e);
    e = edge_n + 1;
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    addr_i = a; rd_i = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_i = 1'b0;
  endtask

  // next bus edge will be edge number t
  task automatic goto(input int t);
    while (edge_n + 1 < t) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    int e, e0, e1, c, d, r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {29'd0, irq_o}, 32'd0);
    bus_rd(8'h00, 32'h0, "R1 enable");
    bus_rd(8'h10, 32'hFFFF_FFFF, "R1 match0");
    bus_rd(8'h22, 32'hFFFF_FFFF, "R1 match2");
    bus_rd(8'h13, 32'h0, "R1 status");
    bus_rd(8'h14, 32'h0, "R1 ien");
    bus_rd(8'h15, 32'h0, "R1 mode");
    bus_rd(8'h16, 32'h0, "R1 capture");
    // R9 unmapped
    bus_rd(8'h3F, 32'h0, "R9 unmapped 3f");
    bus_rd(8'h17, 32'h0, "R9 unmapped 17");
    bus_rd(8'h08, 32'h0, "R9 unmapped 08");

    // timer 1 one-shot style event, delta = 20
    bus_wr(8'h1C, 32'h2, e);
    bus_wr(8'h19, 32'd19, e);
    bus_rd(8'h19, 32'd19, "R9 match1 readback");
    bus_wr(8'h00, 32'h2, e1);
    goto(e1 + 20);
    check("R5 irq before due", {31'd0, irq_o[1]}, 32'd0);
    goto(e1 + 21);
    check("R5 R7 irq at due", {31'd0, irq_o[1]}, 32'd1);
    bus_rd(8'h1B, 32'h2, "R5 status bit1");
    bus_wr(8'h1C, 32'h0, e);
    check("R7 irq masked", {31'd0, irq_o[1]}, 32'd0);
    bus_rd(8'h1B, 32'h2, "R7 status kept under mask");

    // R8 / R3 capture on free-running timer 1
    bus_wr(8'h1E, 32'h1, c);
    bus_rd(8'h1E, 32'(c - e1 - 1), "R8 capture");
    repeat (5) @(negedge clk);
    bus_rd(8'h1E, 32'(c - e1 - 1), "R8 capture held");
    bus_wr(8'h1E, 32'h1, c);
    bus_rd(8'h1E, 32'(c - e1 - 1), "R3 free-running count");

    // R6 zero bits ignored, then clear
    bus_wr(8'h1B, 32'h5, e);
    bus_rd(8'h1B, 32'h2, "R6 zero bits ignored");
    bus_wr(8'h1B, 32'h2, e);
    bus_rd(8'h1B, 32'h0, "R6 cleared");

    // timer 0 periodic, match0 = 4 -> period 5
    bus_wr(8'h10, 32'd4, e);
    bus_wr(8'h15, 32'h1, e);
    bus_wr(8'h14, 32'h1, e);
    bus_wr(8'h00, 32'h3, e0);
    goto(e0 + 8);
    bus_wr(8'h16, 32'h1, c);
    bus_rd(8'h16, 32'((c - e0 - 1) % 5), "R4 periodic count");
    goto(e0 + 10);
    bus_wr(8'h13, 32'h1, e);         // collides with hit at e0+10
    bus_rd(8'h13, 32'h1, "R6 match beats clear");
    goto(e0 + 12);
    bus_wr(8'h13, 32'h1, e);
    bus_rd(8'h13, 32'h0, "R6 clear");
    check("R7 irq0 low after clear", {31'd0, irq_o[0]}, 32'd0);
    goto(e0 + 16);
    check("R4 R7 irq0 on next period", {31'd0, irq_o[0]}, 32'd1);

    // R2 writing 1 to running timer 1 did not restart it
    bus_wr(8'h1E, 32'h1, c);
    bus_rd(8'h1E, 32'(c - e1 - 1), "R2 no restart of running timer");

    // R2 disable timer 0, hold, re-enable
    bus_wr(8'h00, 32'h2, d);
    goto(d + 3);
    bus_wr(8'h16, 32'h1, c);
    bus_rd(8'h16, 32'((d - e0) % 5), "R2 disabled counter holds");
    bus_wr(8'h1E, 32'h1, c);
    bus_rd(8'h1E, 32'(c - e1 - 1), "R2 other timer keeps running");
    bus_wr(8'h00, 32'h3, r);
    goto(r + 3);
    bus_wr(8'h16, 32'h1, c);
    bus_rd(8'h16, 32'(c - r - 1), "R2 restart from zero");
    bus_rd(8'h00, 32'h3, "R9 enable readback");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule